// File: doc/BRIEF.md
# Board Interrupt Aggregator and Control Register Block

This block sits behind a chip select on a 16-bit host bus. It collects eleven external interrupt request lines, turns each rising edge into a sticky pending bit, and drives one combined interrupt line to the host processor. The pending bits are split across two status words: sources 0 to 7 form one word and sources 8 to 10 form the other. The host clears pending bits by writing ones to them. The host keeps servicing while either status word reads nonzero.

A write-only control word sets three options. Retrigger makes the combined output produce a fresh edge when a clear leaves other bits pending. Auto-clear lets a status read also acknowledge the bits it returns. Two further bits drive board outputs: a reset-disable flag and a card-slot reset line. A read-only version byte is fixed at elaboration. It packs the logic revision, the board version and the board issue.

Top module: `irq_regblk`

## Requirements
- R1: The host reaches the registers by byte offset. `addr_i` carries offset bits 2:1. Offset 0x0 (addr 0) is the low status word, 0x2 (addr 1) is the control word, 0x4 (addr 2) is the high status word and 0x6 (addr 3) is the version word. A read takes effect when `cs_i` and `rd_i` are both high, and a write when `cs_i` and `wr_i` are both high.
- R2: A rising edge on a request line sets its pending bit. The bit is visible on `host_irq_o` and through a read after the third rising clock edge that follows the change of the line.
- R3: Sources 0 to 7 map to bits 7:0 of the low status word. Sources 8 to 10 map to bits 2:0 of the high status word. All other status bits read as zero.
- R4: Writing 1 to a status bit clears it. Bits written as 0 keep their value.
- R5: When a new edge and a clear reach the same bit in the same cycle, the bit stays set.
- R6: `host_irq_o` is high whenever any pending bit is set and low when none is, except as stated in R7.
- R7: With control bit 0 (retrigger) set, a status write that clears at least one pending bit while another stays pending drives `host_irq_o` low for exactly one cycle after the write edge. With retrigger clear, the output stays high.
- R8: With control bit 1 (auto-clear) set, a read of a status word clears the bits that the read returned.
- R9: The control word is loaded from write data bits 3:0. Bit 2 drives `rst_dis_o` and bit 3 drives `slot_rst_o`. Reads of offset 0x2 return zero.
- R10: The version word reads {8'h00, revision[2:0], board[1:0], issue[2:0]}, with the revision in bits 7:5, the board in bits 4:3 and the issue in bits 2:0. Writes to it are ignored.
- R11: Requests are edge events. A line held high does not set its bit again after the bit has been cleared.
- R12: Reset clears all pending bits and the control word, so `host_irq_o`, `rst_dis_o` and `slot_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Byte offset bits 2:1 |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero when no read is selected |
| irq_req_i | input | 11 | Asynchronous interrupt request lines |
| host_irq_o | output | 1 | Combined interrupt to the host |
| rst_dis_o | output | 1 | Reset-disable flag from the control word |
| slot_rst_o | output | 1 | Card-slot reset from the control word |

## Verification
The conflict of interest is an edge that reaches a pending bit in the same cycle in which the host clears that bit. The bench sets a bit, lets its line fall, raises the line again and schedules a write-one-to-clear of that bit. The write lands on the exact clock edge at which the synchronized edge arrives. A read-back that returns the bit still set shows that the set won. The same kind of collision between a retrigger clear and the bits still pending is judged by sampling `host_irq_o` in the cycle right after the write and in the cycle after that.

// File: rtl/irq_regblk_pkg.sv
package irq_regblk_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LO_W   = 8;
  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;
  localparam logic [1:0] SEL_VER  = 2'd3;

  typedef struct packed {
    logic slot_rst;
    logic rst_dis;
    logic auto_clr;
    logic retrig;
  } ctrl_t;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] sh_q;  // [0],[1] synchronizer, [2] previous value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], req_i[g]};
    end
    assign rise_o[g] = sh_q[1] & ~sh_q[2];
  end

  // R2: an edge is a single-cycle event
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & $past(rise_o)) == '0);
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end
  assign status_o = status_q;

  a_r4_clear_wins_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~set_i) |=> (status_q & $past(clr_i & ~set_i)) == '0);
  a_r5_set_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> (status_q & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned N = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] wclr_i,
  input  logic         retrig_i,
  output logic         host_irq_o
);
  logic drop_q, drop_d, cleared, remaining;

  assign cleared   = |(status_i & wclr_i & ~set_i);
  assign remaining = |((status_i & ~wclr_i) | set_i);
  assign drop_d    = retrig_i & cleared & remaining;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= drop_d;
  end

  assign host_irq_o = (|status_i) & ~drop_q;

  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == '0) |-> !host_irq_o);
  a_r7_one_cycle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_irq_o && (status_i != '0) |=> host_irq_o || (status_i == '0) || $past(drop_d));
endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
  import irq_regblk_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 11,
  parameter logic [2:0]  VER_REV   = 3'd5,
  parameter logic [1:0]  VER_BOARD = 2'd2,
  parameter logic [2:0]  VER_ISSUE = 3'd1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [15:0]        wdata_i,
  output logic [15:0]        rdata_o,
  input  logic [NUM_SRC-1:0] irq_req_i,
  output logic               host_irq_o,
  output logic               rst_dis_o,
  output logic               slot_rst_o
);
  localparam int unsigned HI_W    = NUM_SRC - LO_W;
  localparam logic [7:0]  VERSION = {VER_REV, VER_BOARD, VER_ISSUE};

  logic rd_en, wr_en, rd_lo, rd_hi, wr_lo, wr_hi, wr_ctrl;
  logic [NUM_SRC-1:0] rise, status, wclr, rclr;
  ctrl_t ctrl_q;
  logic  unused_wdata;

  assign rd_en   = cs_i & rd_i;
  assign wr_en   = cs_i & wr_i;
  assign rd_lo   = rd_en & (addr_i == SEL_LO);
  assign rd_hi   = rd_en & (addr_i == SEL_HI);
  assign wr_lo   = wr_en & (addr_i == SEL_LO);
  assign wr_hi   = wr_en & (addr_i == SEL_HI);
  assign wr_ctrl = wr_en & (addr_i == SEL_CTRL);
  assign unused_wdata = ^wdata_i[15:LO_W];

  irq_edge_capture #(.N(NUM_SRC)) u_cap (
    .clk_i, .rst_ni, .req_i(irq_req_i), .rise_o(rise));

  assign wclr = {wr_hi ? wdata_i[HI_W-1:0] : {HI_W{1'b0}},
                 wr_lo ? wdata_i[LO_W-1:0] : {LO_W{1'b0}}};
  assign rclr = ctrl_q.auto_clr
              ? {rd_hi ? status[NUM_SRC-1:LO_W] : {HI_W{1'b0}},
                 rd_lo ? status[LO_W-1:0]       : {LO_W{1'b0}}}
              : '0;

  irq_status #(.N(NUM_SRC)) u_stat (
    .clk_i, .rst_ni, .set_i(rise), .clr_i(wclr | rclr), .status_o(status));

  irq_out_gen #(.N(NUM_SRC)) u_out (
    .clk_i, .rst_ni, .status_i(status), .set_i(rise), .wclr_i(wclr),
    .retrig_i(ctrl_q.retrig), .host_irq_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[3:0]);
  end
  assign rst_dis_o  = ctrl_q.rst_dis;
  assign slot_rst_o = ctrl_q.slot_rst;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (addr_i)
        SEL_LO:  rdata_o = {{(DATA_W-LO_W){1'b0}}, status[LO_W-1:0]};
        SEL_HI:  rdata_o = {{(DATA_W-HI_W){1'b0}}, status[NUM_SRC-1:LO_W]};
        SEL_VER: rdata_o = {8'h00, VERSION};
        default: rdata_o = '0;
      endcase
    end
  end

  a_r9_ctrl_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl |=> $stable({rst_dis_o, slot_rst_o}));
  a_r9_ctrl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && addr_i == SEL_CTRL) |-> rdata_o == '0);
  a_r3_hi_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi |-> rdata_o[DATA_W-1:HI_W] == '0);
  a_r8_autoclr_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo && ctrl_q.auto_clr && !wr_en) |=>
      (status[LO_W-1:0] & $past(rdata_o[LO_W-1:0]) & ~$past(rise[LO_W-1:0])) == '0);
endmodule

// File: tb/irq_regblk_tb.sv
module irq_regblk_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [10:0] req = '0;
  logic host_irq, rst_dis, slot_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_regblk u_dut (
    .clk_i(clk), .rst_ni, .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_req_i(req),
    .host_irq_o(host_irq), .rst_dis_o(rst_dis), .slot_rst_o(slot_rst));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic pulse(logic [10:0] m);
    @(negedge clk); req = m;
    repeat (3) @(negedge clk);
    req = '0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] lo_of(logic [10:0] s); return {8'h00, s[7:0]}; endfunction
  function automatic logic [15:0] hi_of(logic [10:0] s); return {13'h0, s[10:8]}; endfunction

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    logic [10:0] exp;
    logic [10:0] m, c;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R12: reset state
    check("R12 host_irq", {15'h0, host_irq}, 16'h0);
    check("R12 ctrl outs", {14'h0, rst_dis, slot_rst}, 16'h0);
    bus_rd(2'd0, d); check("R12 low status", d, 16'h0);
    // R10: version, writes ignored
    bus_wr(2'd3, 16'hFFFF);
    bus_rd(2'd3, d); check("R10 version", d, 16'h00B1);
    // R9: control outputs and zero read
    bus_wr(2'd1, 16'h000C);
    check("R9 ctrl outs", {14'h0, rst_dis, slot_rst}, 16'h0003);
    bus_rd(2'd1, d); check("R9 ctrl read", d, 16'h0);
    bus_wr(2'd1, 16'h0000);
    // R2: latency measured on host_irq
    @(negedge clk); req[5] = 1;
    @(negedge clk); check("R2 lat1", {15'h0, host_irq}, 16'h0);
    @(negedge clk); check("R2 lat2", {15'h0, host_irq}, 16'h0);
    @(negedge clk); check("R2 lat3", {15'h0, host_irq}, 16'h1);
    req[5] = 0;
    bus_rd(2'd0, d); check("R2 bit5", d, 16'h0020);
    // R3: high word mapping
    pulse(11'h200);
    bus_rd(2'd2, d); check("R3 high bit1", d, 16'h0002);
    bus_rd(2'd0, d); check("R3 low unchanged", d, 16'h0020);
    // R4: write-one-to-clear, zeros kept
    bus_wr(2'd0, 16'h0000);
    bus_rd(2'd0, d); check("R4 zero write", d, 16'h0020);
    bus_wr(2'd0, 16'h0020); bus_wr(2'd2, 16'h0002);
    bus_rd(2'd0, d); check("R4 low cleared", d, 16'h0);
    bus_rd(2'd2, d); check("R4 high cleared", d, 16'h0);
    check("R6 idle", {15'h0, host_irq}, 16'h0);
    // R5: set vs clear on the same edge
    pulse(11'h001);
    @(negedge clk); req[0] = 1;
    @(negedge clk);
    bus_wr(2'd0, 16'h0001);
    bus_rd(2'd0, d); check("R5 set wins", d, 16'h0001);
    req[0] = 0;
    bus_wr(2'd0, 16'h0001);
    // R7: retrigger gap
    bus_wr(2'd1, 16'h0001);
    pulse(11'h003);
    bus_wr(2'd0, 16'h0001);
    check("R7 gap low", {15'h0, host_irq}, 16'h0);
    @(negedge clk); check("R7 gap end", {15'h0, host_irq}, 16'h1);
    bus_wr(2'd0, 16'h0002);
    @(negedge clk); check("R7 last cleared", {15'h0, host_irq}, 16'h0);
    bus_wr(2'd1, 16'h0000);
    pulse(11'h003);
    bus_wr(2'd0, 16'h0001);
    check("R7 no retrig", {15'h0, host_irq}, 16'h1);
    bus_wr(2'd0, 16'h0002);
    // R8: auto-clear on read
    bus_wr(2'd1, 16'h0002);
    pulse(11'h481);
    bus_rd(2'd0, d); check("R8 first low", d, 16'h0081);
    bus_rd(2'd0, d); check("R8 low gone", d, 16'h0);
    bus_rd(2'd2, d); check("R8 first high", d, 16'h0004);
    bus_rd(2'd2, d); check("R8 high gone", d, 16'h0);
    bus_wr(2'd1, 16'h0000);
    // R11: level held does not re-set
    @(negedge clk); req[3] = 1;
    repeat (4) @(negedge clk);
    bus_wr(2'd0, 16'h0008);
    repeat (4) @(negedge clk);
    bus_rd(2'd0, d); check("R11 level held", d, 16'h0);
    req[3] = 0;
    repeat (3) @(negedge clk);
    // R1/R3/R4/R6: random
    exp = '0;
    for (int i = 0; i < 40; i++) begin
      m = 11'($urandom) & 11'h7FF;
      pulse(m);
      exp |= m;
      bus_rd(2'd0, d); check("R1 rand low", d, lo_of(exp));
      bus_rd(2'd2, d); check("R3 rand high", d, hi_of(exp));
      check("R6 rand irq", {15'h0, host_irq}, {15'h0, |exp});
      c = 11'($urandom);
      bus_wr(2'd0, {8'h00, c[7:0]});
      bus_wr(2'd2, {13'h0, c[10:8]});
      exp &= ~c;
    end
    // R12: reset mid-run
    pulse(11'h7FF);
    bus_wr(2'd1, 16'h000F);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    check("R12 irq after reset", {15'h0, host_irq}, 16'h0);
    check("R12 ctrl after reset", {14'h0, rst_dis, slot_rst}, 16'h0);
    bus_rd(2'd0, d); check("R12 low after reset", d, 16'h0);
    bus_rd(2'd2, d); check("R12 high after reset", d, 16'h0);
    finish_run();
  end
endmodule